// File: doc/BRIEF.md
# Condition Flag Register and Branch Condition Tester

This block holds a processor's four arithmetic condition flags (negative, zero, carry, overflow) and decides, for a 4-bit condition selector, whether a conditional control-flow operation should proceed. The single "condition true" output gates every jump, branch, subroutine call and subroutine return. A return is treated the same way as the other flow-control operations.

The flags are loaded from the ALU when it writes them. Two direct commands also change them, each taking a 4-bit mask: one sets bits by OR-ing the mask into the flags and the other clears bits by AND-ing the mask into the flags. These commands update the register in the cycle they are asserted, and they take precedence over an ALU write in that cycle.

The selector encoding follows the familiar sixteen-entry condition family with a different numbering. Code 0 is "always" and code 15 is "never". Carry is used as produced, with no inversion after subtraction, so C = 1 means an unsigned borrow. A parameter chooses whether the condition output is combinational or registered.

Top module: `cc_unit`

## Requirements
- R1: While reset is asserted and after it is released, with no command applied, the flags equal the parameter RESET_FLAGS (default 4'b0000).
- R2: An ALU write (alu_flags_we_i = 1, no OR or AND command) loads alu_flags_i into the flags at the next rising edge. The flag bit order is N = bit 3, Z = bit 2, C = bit 1, V = bit 0.
- R3: An OR command alone sets the flags to flags | flag_mask_i at the next rising edge.
- R4: An AND command alone sets the flags to flags & flag_mask_i at the next rising edge.
- R5: When the OR and AND commands are asserted together, the OR is applied first and the AND second, so the flags become (flags | mask) & mask, which equals the mask.
- R6: When an OR or AND command is asserted in the same cycle as an ALU write, the command result is stored and the ALU value is discarded.
- R7: With no write and no command, the flags hold their value whatever alu_flags_i and flag_mask_i carry.
- R8: Selector 0 evaluates true and selector 15 evaluates false for every flag value.
- R9: Selectors 1 through 8 test one flag each: 1 Z, 2 !Z, 3 C, 4 !C, 5 N, 6 !N, 7 V, 8 !V.
- R10: The unsigned comparisons use a carry that is not inverted. Selector 9 (higher) is !C & !Z. Selector 10 (lower or same) is C | Z.
- R11: The signed comparisons are as follows. Selector 11 is N == V. Selector 12 is N != V. Selector 13 is !Z & (N == V). Selector 14 is Z | (N != V).
- R12: With PIPE_COND = 0, cond_true_o follows cond_sel_i and the flags combinationally. With PIPE_COND = 1, cond_true_o is registered: after each rising edge it shows the result for the selector and flags present before that edge, and it is 0 during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| alu_flags_i | input | 4 | Flags produced by the ALU, {N,Z,C,V} |
| alu_flags_we_i | input | 1 | ALU flag write enable |
| flag_or_i | input | 1 | OR the mask into the flags |
| flag_and_i | input | 1 | AND the mask into the flags |
| flag_mask_i | input | 4 | Mask for the OR and AND commands |
| cond_sel_i | input | 4 | Branch condition selector |
| flags_o | output | 4 | Current flags, {N,Z,C,V} |
| cond_true_o | output | 1 | Selected condition holds |

## Verification
The bench builds two copies of the block: one with the default combinational condition output (PIPE_COND = 0) and one with the registered output (PIPE_COND = 1). Both copies use RESET_FLAGS = 0. Because the flag state and the mask are each only four bits wide, the bench sweeps every pairing of flag value with selector, and every pairing of flag value with mask for each command. Every condition code, every update rule and the one-cycle lag of the registered variant are therefore checked against results the bench computes itself, rather than against samples.

// File: rtl/cc_pkg.sv
package cc_pkg;

   localparam int unsigned CC_FLAG_W = 4;
   localparam int unsigned CC_SEL_W  = 4;

   localparam int unsigned CC_BIT_V = 0;
   localparam int unsigned CC_BIT_C = 1;
   localparam int unsigned CC_BIT_Z = 2;
   localparam int unsigned CC_BIT_N = 3;

   typedef logic [CC_FLAG_W-1:0] cc_flags_t;

   typedef enum logic [CC_SEL_W-1:0] {
      CC_ALWAYS = 4'd0,
      CC_ZSET   = 4'd1,
      CC_ZCLR   = 4'd2,
      CC_CSET   = 4'd3,
      CC_CCLR   = 4'd4,
      CC_NSET   = 4'd5,
      CC_NCLR   = 4'd6,
      CC_VSET   = 4'd7,
      CC_VCLR   = 4'd8,
      CC_UHI    = 4'd9,
      CC_ULS    = 4'd10,
      CC_SGE    = 4'd11,
      CC_SLT    = 4'd12,
      CC_SGT    = 4'd13,
      CC_SLE    = 4'd14,
      CC_NEVER  = 4'd15
   } cc_sel_e;

endpackage

// File: rtl/cc_flag_reg.sv
module cc_flag_reg
   import cc_pkg::*;
#(
   parameter int unsigned FLAG_W      = CC_FLAG_W,
   parameter logic [FLAG_W-1:0] RESET_FLAGS = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [FLAG_W-1:0] alu_flags_i,
   input  logic              alu_we_i,
   input  logic              or_en_i,
   input  logic              and_en_i,
   input  logic [FLAG_W-1:0] mask_i,
   output logic [FLAG_W-1:0] flags_o
);

   logic [FLAG_W-1:0] flags_q;
   logic              cmd_any;

   assign cmd_any = or_en_i | and_en_i;

   for (genvar b = 0; b < FLAG_W; b++) begin : g_bit
      logic after_or;
      logic after_and;
      logic bit_d;

      always_comb begin
         after_or  = or_en_i  ? (flags_q[b] | mask_i[b]) : flags_q[b];
         after_and = and_en_i ? (after_or   & mask_i[b]) : after_or;
         if (cmd_any) begin
            bit_d = after_and;
         end else if (alu_we_i) begin
            bit_d = alu_flags_i[b];
         end else begin
            bit_d = flags_q[b];
         end
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            flags_q[b] <= RESET_FLAGS[b];
         end else begin
            flags_q[b] <= bit_d;
         end
      end
   end

   assign flags_o = flags_q;

endmodule

// File: rtl/cc_cond_eval.sv
module cc_cond_eval
   import cc_pkg::*;
(
   input  logic [CC_SEL_W-1:0]  sel_i,
   input  logic [CC_FLAG_W-1:0] flags_i,
   output logic                 hit_o
);

   logic fn, fz, fc, fv;
   logic sgn_eq;

   assign fn     = flags_i[CC_BIT_N];
   assign fz     = flags_i[CC_BIT_Z];
   assign fc     = flags_i[CC_BIT_C];
   assign fv     = flags_i[CC_BIT_V];
   assign sgn_eq = ~(fn ^ fv);

   always_comb begin
      hit_o = 1'b0;
      case (cc_sel_e'(sel_i))
         CC_ALWAYS: hit_o = 1'b1;
         CC_ZSET:   hit_o = fz;
         CC_ZCLR:   hit_o = ~fz;
         CC_CSET:   hit_o = fc;
         CC_CCLR:   hit_o = ~fc;
         CC_NSET:   hit_o = fn;
         CC_NCLR:   hit_o = ~fn;
         CC_VSET:   hit_o = fv;
         CC_VCLR:   hit_o = ~fv;
         CC_UHI:    hit_o = ~fc & ~fz;
         CC_ULS:    hit_o = fc | fz;
         CC_SGE:    hit_o = sgn_eq;
         CC_SLT:    hit_o = ~sgn_eq;
         CC_SGT:    hit_o = ~fz & sgn_eq;
         CC_SLE:    hit_o = fz | ~sgn_eq;
         CC_NEVER:  hit_o = 1'b0;
      endcase
   end

endmodule

// File: rtl/cc_unit.sv
module cc_unit
   import cc_pkg::*;
#(
   parameter int unsigned FLAG_W      = CC_FLAG_W,
   parameter int unsigned SEL_W       = CC_SEL_W,
   parameter int unsigned PIPE_COND   = 0,
   parameter logic [FLAG_W-1:0] RESET_FLAGS = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [FLAG_W-1:0] alu_flags_i,
   input  logic              alu_flags_we_i,
   input  logic              flag_or_i,
   input  logic              flag_and_i,
   input  logic [FLAG_W-1:0] flag_mask_i,
   input  logic [SEL_W-1:0]  cond_sel_i,
   output logic [FLAG_W-1:0] flags_o,
   output logic              cond_true_o
);

   if (FLAG_W != CC_FLAG_W) begin : g_bad_flag_w
      $error("cc_unit: FLAG_W must be %0d", CC_FLAG_W);
   end
   if (SEL_W != CC_SEL_W) begin : g_bad_sel_w
      $error("cc_unit: SEL_W must be %0d", CC_SEL_W);
   end
   if (PIPE_COND > 1) begin : g_bad_pipe
      $error("cc_unit: PIPE_COND must be 0 or 1");
   end

   logic [FLAG_W-1:0] flags_cur;
   logic              hit_comb;

   cc_flag_reg #(
      .FLAG_W      (FLAG_W),
      .RESET_FLAGS (RESET_FLAGS)
   ) u_flags (
      .clk         (clk),
      .rst_n       (rst_n),
      .alu_flags_i (alu_flags_i),
      .alu_we_i    (alu_flags_we_i),
      .or_en_i     (flag_or_i),
      .and_en_i    (flag_and_i),
      .mask_i      (flag_mask_i),
      .flags_o     (flags_cur)
   );

   cc_cond_eval u_eval (
      .sel_i   (cond_sel_i),
      .flags_i (flags_cur),
      .hit_o   (hit_comb)
   );

   if (PIPE_COND != 0) begin : g_cond_reg
      logic hit_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            hit_q <= 1'b0;
         end else begin
            hit_q <= hit_comb;
         end
      end
      assign cond_true_o = hit_q;
   end else begin : g_cond_comb
      assign cond_true_o = hit_comb;
   end

   assign flags_o = flags_cur;

endmodule

// File: rtl/cc_unit_chk.sv
module cc_unit_chk #(
   parameter int unsigned FLAG_W      = 4,
   parameter int unsigned SEL_W       = 4,
   parameter int unsigned PIPE_COND   = 0,
   parameter logic [FLAG_W-1:0] RESET_FLAGS = '0
) (
   input logic              clk,
   input logic              rst_n,
   input logic [FLAG_W-1:0] alu_flags_i,
   input logic              alu_flags_we_i,
   input logic              flag_or_i,
   input logic              flag_and_i,
   input logic [FLAG_W-1:0] flag_mask_i,
   input logic [SEL_W-1:0]  cond_sel_i,
   input logic [FLAG_W-1:0] flags_o,
   input logic              cond_true_o
);

   AST_ALU_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (alu_flags_we_i && !flag_or_i && !flag_and_i) |=> (flags_o == $past(alu_flags_i))); // R2

   AST_OR_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_or_i && !flag_and_i) |=> (flags_o == ($past(flags_o) | $past(flag_mask_i)))); // R3

   AST_AND_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_and_i && !flag_or_i) |=> (flags_o == ($past(flags_o) & $past(flag_mask_i)))); // R4

   AST_BOTH_CMDS: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_or_i && flag_and_i) |=> (flags_o == $past(flag_mask_i))); // R5

   AST_CMD_OVER_ALU: assert property (@(posedge clk) disable iff (!rst_n)
      (alu_flags_we_i && flag_or_i && !flag_and_i)
      |=> (flags_o == ($past(flags_o) | $past(flag_mask_i)))); // R6

   AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!alu_flags_we_i && !flag_or_i && !flag_and_i) |=> $stable(flags_o)); // R7

   if (PIPE_COND == 0) begin : g_comb_chk
      AST_SEL_ALWAYS: assert property (@(posedge clk) disable iff (!rst_n)
         (cond_sel_i == '0) |-> cond_true_o); // R8
      AST_SEL_NEVER: assert property (@(posedge clk) disable iff (!rst_n)
         (cond_sel_i == '1) |-> !cond_true_o); // R8
   end else begin : g_pipe_chk
      AST_SEL_ALWAYS: assert property (@(posedge clk) disable iff (!rst_n)
         (cond_sel_i == '0) |=> cond_true_o); // R12
      AST_SEL_NEVER: assert property (@(posedge clk) disable iff (!rst_n)
         (cond_sel_i == '1) |=> !cond_true_o); // R12
   end

endmodule

bind cc_unit cc_unit_chk #(
   .FLAG_W      (FLAG_W),
   .SEL_W       (SEL_W),
   .PIPE_COND   (PIPE_COND),
   .RESET_FLAGS (RESET_FLAGS)
) u_chk (.*);

// File: tb/cc_unit_tb.sv
`timescale 1ns/1ps
module cc_unit_tb;

   logic       clk = 1'b0;
   logic       rst_n;
   logic [3:0] alu_flags;
   logic       alu_we;
   logic       or_en;
   logic       and_en;
   logic [3:0] mask;
   logic [3:0] sel;
   logic [3:0] flags_c, flags_p;
   logic       cond_c, cond_p;

   int tests = 0;
   int fails = 0;

   always #5 clk = ~clk;

   cc_unit #(.PIPE_COND(0)) u_dut (
      .clk(clk), .rst_n(rst_n), .alu_flags_i(alu_flags), .alu_flags_we_i(alu_we),
      .flag_or_i(or_en), .flag_and_i(and_en), .flag_mask_i(mask),
      .cond_sel_i(sel), .flags_o(flags_c), .cond_true_o(cond_c));

   cc_unit #(.PIPE_COND(1)) u_dut_p (
      .clk(clk), .rst_n(rst_n), .alu_flags_i(alu_flags), .alu_flags_we_i(alu_we),
      .flag_or_i(or_en), .flag_and_i(and_en), .flag_mask_i(mask),
      .cond_sel_i(sel), .flags_o(flags_p), .cond_true_o(cond_p));

   function automatic logic expect_cond(input logic [3:0] s, input logic [3:0] f);
      logic n, z, c, v;
      n = f[3]; z = f[2]; c = f[1]; v = f[0];
      case (s)
         4'd0:  return 1'b1;
         4'd1:  return z;
         4'd2:  return !z;
         4'd3:  return c;
         4'd4:  return !c;
         4'd5:  return n;
         4'd6:  return !n;
         4'd7:  return v;
         4'd8:  return !v;
         4'd9:  return !c && !z;
         4'd10: return c || z;
         4'd11: return n == v;
         4'd12: return n != v;
         4'd13: return !z && (n == v);
         4'd14: return z || (n != v);
         default: return 1'b0;
      endcase
   endfunction

   function automatic string sel_req(input logic [3:0] s);
      if (s == 4'd0 || s == 4'd15) return "R8";
      if (s <= 4'd8) return "R9";
      if (s <= 4'd10) return "R10";
      return "R11";
   endfunction

   task automatic check(input string req, input logic [3:0] got, input logic [3:0] exp);
      tests++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic step(input logic we, input logic [3:0] af, input logic o,
                       input logic a, input logic [3:0] m);
      @(negedge clk);
      alu_we = we; alu_flags = af; or_en = o; and_en = a; mask = m;
      @(posedge clk);
      #1;
      alu_we = 1'b0; or_en = 1'b0; and_en = 1'b0;
   endtask

   task automatic load(input logic [3:0] f);
      step(1'b1, f, 1'b0, 1'b0, 4'h0);
   endtask

   initial begin
      #1_000_000;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      rst_n = 1'b0; alu_flags = 4'h0; alu_we = 1'b0; or_en = 1'b0;
      and_en = 1'b0; mask = 4'h0; sel = 4'h0;
      repeat (3) @(posedge clk);
      #1;
      check("R1 reset flags", flags_c, 4'h0);
      check("R1 reset flags pipe", flags_p, 4'h0);
      check("R12 pipe cond in reset", {3'b0, cond_p}, 4'h0);
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk);
      #1;
      check("R1 flags after release", flags_c, 4'h0);

      // R2 and R8..R12: every flag value against every selector
      for (int f = 0; f < 16; f++) begin
         load(4'(f));
         check("R2 alu load", flags_c, 4'(f));
         check("R2 alu load pipe", flags_p, 4'(f));
         for (int s = 0; s < 16; s++) begin
            sel = 4'(s);
            #1;
            check(sel_req(4'(s)), {3'b0, cond_c}, {3'b0, expect_cond(4'(s), 4'(f))});
            @(posedge clk);
            #1;
            check("R12 registered cond", {3'b0, cond_p}, {3'b0, expect_cond(4'(s), 4'(f))});
         end
      end
      sel = 4'h0;

      // R3, R4, R5 sweeps
      for (int f = 0; f < 16; f++) begin
         for (int m = 0; m < 16; m++) begin
            load(4'(f));
            step(1'b0, 4'h0, 1'b1, 1'b0, 4'(m));
            check("R3 or", flags_c, 4'(f) | 4'(m));
            load(4'(f));
            step(1'b0, 4'h0, 1'b0, 1'b1, 4'(m));
            check("R4 and", flags_c, 4'(f) & 4'(m));
            load(4'(f));
            step(1'b0, 4'h0, 1'b1, 1'b1, 4'(m));
            check("R5 both", flags_c, 4'(m));
         end
      end

      // R6 priority over ALU write, R7 hold
      for (int f = 0; f < 16; f++) begin
         for (int m = 0; m < 16; m += 5) begin
            load(4'(f));
            step(1'b1, ~4'(f), 1'b1, 1'b0, 4'(m));
            check("R6 or over alu", flags_c, 4'(f) | 4'(m));
            load(4'(f));
            step(1'b1, ~4'(f), 1'b0, 1'b1, 4'(m));
            check("R6 and over alu", flags_c, 4'(f) & 4'(m));
            load(4'(f));
            step(1'b1, ~4'(f), 1'b1, 1'b1, 4'(m));
            check("R6 both over alu", flags_c, 4'(m));
         end
         load(4'(f));
         step(1'b0, ~4'(f), 1'b0, 1'b0, ~4'(f));
         step(1'b0, 4'hF, 1'b0, 1'b0, 4'h0);
         check("R7 hold", flags_c, 4'(f));
         check("R7 hold pipe", flags_p, 4'(f));
      end

      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule